// File: doc/BRIEF.md
# Interrupt Migration Command Decoder

This block carries out one "move every pending interrupt" command from a command queue held in memory. A command is four 64-bit doublewords. The first two carry nothing this block needs, so it reads only the third and fourth. Each of those holds a target index. The caller offers the command's byte address and opcode. The block then fetches the two index-bearing words through a single-outstanding read port and checks each index against the configured target count. It then either starts the migration engine or retires the command with no action.

The result is a one-cycle pulse with two flags. One flag marks a stall: a memory fault means the queue must not advance. The other marks a logged range error: the command was malformed but still retires. When the engine is started, the block waits for its completion before it retires the command. Queue pointers, other opcodes and the data movement itself belong to neighbouring blocks.

Top module: `irq_move_cmd`

## Requirements
- R1: A command is taken only when `cmd_ready` is high, `cmd_valid` is high and `cmd_opcode` equals 8'h0E. Any other opcode causes no read and no result.
- R2: The block issues at most two reads per command. The first is at `cmd_base`+16 and the second at `cmd_base`+24. A request holds its address until `rd_req_ready` accepts it, and only one read is outstanding at a time.
- R3: A target index is bits 51:16 of the read word. Bits 63:52 and 15:0 have no effect.
- R4: A read that returns `rd_rsp_err` retires the command with `res_stall`=1 and `res_log_err`=0, and no `mv_start`.
- R5: If the first index is greater than or equal to `num_targets`, the command retires with `res_stall`=0 and `res_log_err`=1. The second word is not read and no move is started.
- R6: If the second index is greater than or equal to `num_targets`, the command retires with `res_stall`=0 and `res_log_err`=1, and no move is started.
- R7: If both indices are in range and equal, the command retires with both flags 0 and no move.
- R8: If both indices are in range and differ, `mv_start` pulses for one cycle with `mv_src` set to the first index and `mv_dst` set to the second. The result (both flags 0) follows only after `mv_done`. A `mv_done` seen at any other time is ignored.
- R9: `res_valid` is a one-cycle pulse per taken command. After reset `cmd_ready`=1, and `rd_req_valid`, `mv_start` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_opcode | input | 8 | Opcode from the low byte of the first doubleword |
| cmd_base | input | ADDR_W | Byte address of the command |
| cmd_ready | output | 1 | Idle, able to take a command |
| num_targets | input | IDX_W | Number of valid targets |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_err | input | 1 | Read response fault |
| rd_rsp_data | input | 64 | Read data, little-endian doubleword |
| mv_start | output | 1 | Start pulse to the migration engine |
| mv_src | output | IDX_W | Source target index |
| mv_dst | output | IDX_W | Destination target index |
| mv_done | input | 1 | Migration engine finished |
| res_valid | output | 1 | Command result pulse |
| res_stall | output | 1 | 1 means stall, 0 means continue |
| res_log_err | output | 1 | Range error to be logged |

## Verification
Retiring one command and taking the next can happen at the same clock edge. The block returns to idle in the cycle its result pulse is raised, so a command already waiting at the input is taken on that edge. The bench provokes this by queueing commands one after another without waiting for results, with the read port's ready toggling. The scoreboard judges each result pulse against exactly one expected item, including the number and addresses of the reads that belong to it. A read that starts in the retire cycle must therefore be counted towards the next command and not the one being retired.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam logic [7:0] OPC_MOVE_ALL = 8'h0E;
  localparam int DW_BYTES = 8;
  localparam int WORD_A_OFF = 2 * DW_BYTES;
  localparam int WORD_B_OFF = 3 * DW_BYTES;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH_A,
    S_FETCH_B,
    S_MOVE
  } imc_state_e;
endpackage

// File: rtl/imc_index_field.sv
module imc_index_field #(
  parameter int DATA_W = 64,
  parameter int IDX_LSB = 16,
  parameter int IDX_W = 36
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  limit,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  always_comb begin
    idx      = word[IDX_MSB:IDX_LSB];
    in_range = (idx < limit);
  end
endmodule

// File: rtl/imc_seq.sv
module imc_seq
  import imc_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_take,
  input  logic [ADDR_W-1:0] cmd_base,
  output logic              cmd_ready,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic              rd_rsp_err,
  input  logic [IDX_W-1:0]  fld_idx,
  input  logic              fld_ok,
  output logic              mv_start,
  output logic [IDX_W-1:0]  mv_src,
  output logic [IDX_W-1:0]  mv_dst,
  input  logic              mv_done,
  output logic              res_valid,
  output logic              res_stall,
  output logic              res_log_err
);
  localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(WORD_A_OFF);
  localparam logic [ADDR_W-1:0] OFF_B = ADDR_W'(WORD_B_OFF);

  imc_state_e        state;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  first_q;
  logic              rsp_take;

  assign cmd_ready = (state == S_IDLE);
  assign rsp_take  = rd_rsp_valid && !rd_req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      base_q       <= '0;
      first_q      <= '0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      mv_start     <= 1'b0;
      mv_src       <= '0;
      mv_dst       <= '0;
      res_valid    <= 1'b0;
      res_stall    <= 1'b0;
      res_log_err  <= 1'b0;
    end else begin
      mv_start  <= 1'b0;
      res_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) rd_req_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_take) begin
            base_q       <= cmd_base;
            rd_req_addr  <= cmd_base + OFF_A;
            rd_req_valid <= 1'b1;
            state        <= S_FETCH_A;
          end
        end
        S_FETCH_A: begin
          if (rsp_take) begin
            if (rd_rsp_err) begin
              res_valid <= 1'b1; res_stall <= 1'b1; res_log_err <= 1'b0;
              state     <= S_IDLE;
            end else if (!fld_ok) begin
              res_valid <= 1'b1; res_stall <= 1'b0; res_log_err <= 1'b1;
              state     <= S_IDLE;
            end else begin
              first_q      <= fld_idx;
              rd_req_addr  <= base_q + OFF_B;
              rd_req_valid <= 1'b1;
              state        <= S_FETCH_B;
            end
          end
        end
        S_FETCH_B: begin
          if (rsp_take) begin
            if (rd_rsp_err) begin
              res_valid <= 1'b1; res_stall <= 1'b1; res_log_err <= 1'b0;
              state     <= S_IDLE;
            end else if (!fld_ok) begin
              res_valid <= 1'b1; res_stall <= 1'b0; res_log_err <= 1'b1;
              state     <= S_IDLE;
            end else if (fld_idx == first_q) begin
              res_valid <= 1'b1; res_stall <= 1'b0; res_log_err <= 1'b0;
              state     <= S_IDLE;
            end else begin
              mv_src   <= first_q;
              mv_dst   <= fld_idx;
              mv_start <= 1'b1;
              state    <= S_MOVE;
            end
          end
        end
        S_MOVE: begin
          if (mv_done) begin
            res_valid <= 1'b1; res_stall <= 1'b0; res_log_err <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_move_cmd.sv
module irq_move_cmd
  import imc_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int IDX_LSB = 16,
  parameter int IDX_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_opcode,
  input  logic [ADDR_W-1:0] cmd_base,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  num_targets,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic              rd_rsp_err,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              mv_start,
  output logic [IDX_W-1:0]  mv_src,
  output logic [IDX_W-1:0]  mv_dst,
  input  logic              mv_done,
  output logic              res_valid,
  output logic              res_stall,
  output logic              res_log_err
);
  logic             cmd_take;
  logic [IDX_W-1:0] fld_idx;
  logic             fld_ok;

  assign cmd_take = cmd_valid && cmd_ready && (cmd_opcode == OPC_MOVE_ALL);

  imc_index_field #(
    .DATA_W (DATA_W),
    .IDX_LSB(IDX_LSB),
    .IDX_W  (IDX_W)
  ) u_field (
    .word    (rd_rsp_data),
    .limit   (num_targets),
    .idx     (fld_idx),
    .in_range(fld_ok)
  );

  imc_seq #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_take    (cmd_take),
    .cmd_base    (cmd_base),
    .cmd_ready   (cmd_ready),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_err  (rd_rsp_err),
    .fld_idx     (fld_idx),
    .fld_ok      (fld_ok),
    .mv_start    (mv_start),
    .mv_src      (mv_src),
    .mv_dst      (mv_dst),
    .mv_done     (mv_done),
    .res_valid   (res_valid),
    .res_stall   (res_stall),
    .res_log_err (res_log_err)
  );
endmodule

// File: rtl/imc_checker.sv
module imc_checker #(
  parameter int ADDR_W = 48,
  parameter int IDX_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic [IDX_W-1:0]  num_targets,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              mv_start,
  input logic [IDX_W-1:0]  mv_src,
  input logic [IDX_W-1:0]  mv_dst,
  input logic              res_valid,
  input logic              res_stall,
  input logic              res_log_err
);
  p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_idle_no_read_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !rd_req_valid);

  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_stall |-> !res_log_err);

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mv_start |=> !mv_start);

  p_start_legal_r8: assert property (@(posedge clk) disable iff (rst)
    mv_start |-> (mv_src != mv_dst) && (mv_src < num_targets) && (mv_dst < num_targets));

  p_start_not_result_r8: assert property (@(posedge clk) disable iff (rst)
    mv_start |-> !res_valid && !rd_req_valid);

  p_result_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

bind irq_move_cmd imc_checker #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_ready   (cmd_ready),
  .num_targets (num_targets),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .mv_start    (mv_start),
  .mv_src      (mv_src),
  .mv_dst      (mv_dst),
  .res_valid   (res_valid),
  .res_stall   (res_stall),
  .res_log_err (res_log_err)
);

// File: tb/tb_irq_move_cmd.sv
module tb_irq_move_cmd;
  localparam int ADDR_W = 48;
  localparam int IDX_W = 36;
  localparam int NT = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [7:0]        cmd_opcode = 8'h00;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic              cmd_ready;
  logic [IDX_W-1:0]  num_targets = IDX_W'(NT);
  logic              rd_req_valid;
  logic              rd_req_ready = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid = 1'b0;
  logic              rd_rsp_err = 1'b0;
  logic [63:0]       rd_rsp_data = '0;
  logic              mv_start;
  logic [IDX_W-1:0]  mv_src, mv_dst;
  logic              mv_done;
  logic              eng_done = 1'b0;
  logic              spur_done = 1'b0;
  logic              res_valid, res_stall, res_log_err;

  assign mv_done = eng_done | spur_done;

  always #5 clk = ~clk;

  irq_move_cmd #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_base(cmd_base), .cmd_ready(cmd_ready), .num_targets(num_targets),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .rd_rsp_data(rd_rsp_data),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_done(mv_done),
    .res_valid(res_valid), .res_stall(res_stall), .res_log_err(res_log_err)
  );

  typedef struct {
    logic              stall;
    logic              log_err;
    logic              moved;
    logic [IDX_W-1:0]  src;
    logic [IDX_W-1:0]  dst;
    int                nreads;
    logic [ADDR_W-1:0] base;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int total_reads = 0;
  int results_seen = 0;

  logic [63:0] mem [longint];
  bit          bad [longint];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // memory model: toggling ready, fixed latency, error injection
  int rdy_cnt = 0;
  int lat = 0;
  logic [ADDR_W-1:0] pend_addr;
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
    rdy_cnt++;
    rd_req_ready = (rdy_cnt % 3) != 0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_err   = bad.exists(longint'(pend_addr));
        rd_rsp_data  = mem.exists(longint'(pend_addr)) ? mem[longint'(pend_addr)] : 64'h0;
      end
    end
    if (!rst && rd_req_valid && rd_req_ready) begin
      pend_addr = rd_req_addr;
      lat = 2;
    end
  end

  // migration engine model
  int eng_cnt = 0;
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (!rst && mv_start) eng_cnt = 4;
    else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) eng_done = 1'b1;
    end
  end

  // monitor: scoreboard compare
  int cur_reads = 0;
  logic [ADDR_W-1:0] cur_addr [2];
  bit started = 0, done_seen = 0;
  logic [IDX_W-1:0] got_src, got_dst;
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      if (res_valid) begin
        results_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(res_stall == e.stall, e.req, "res_stall", res_stall, e.stall);
          check(res_log_err == e.log_err, e.req, "res_log_err", res_log_err, e.log_err);
          check(started == e.moved, e.req, "move started", started, e.moved);
          check(cur_reads == e.nreads, e.req, "read count (R2)", cur_reads, e.nreads);
          if (cur_reads >= 1)
            check(cur_addr[0] == e.base + 16, "R2", "first address", cur_addr[0], e.base + 16);
          if (cur_reads >= 2)
            check(cur_addr[1] == e.base + 24, "R2", "second address", cur_addr[1], e.base + 24);
          if (e.moved) begin
            check(got_src == e.src, "R8", "mv_src", got_src, e.src);
            check(got_dst == e.dst, "R8", "mv_dst", got_dst, e.dst);
            check(done_seen, "R8", "result before done", done_seen, 1);
          end
        end
        cur_reads = 0; started = 0; done_seen = 0;
      end
      if (mv_done && started) done_seen = 1;
      if (mv_start) begin
        started = 1; got_src = mv_src; got_dst = mv_dst;
      end
      if (rd_req_valid && rd_req_ready) begin
        if (cur_reads < 2) cur_addr[cur_reads] = rd_req_addr;
        cur_reads++;
        total_reads++;
      end
    end
  end

  function automatic logic [63:0] mk_word(input logic [IDX_W-1:0] idx, input logic [11:0] hi,
                                          input logic [15:0] lo);
    return {hi, idx, lo};
  endfunction

  // driver: place command words, push expectation, offer command
  task automatic issue(input logic [ADDR_W-1:0] base, input logic [63:0] wa, input logic [63:0] wb,
                       input bit bad_a, input bit bad_b, input exp_t e);
    mem[longint'(base + 16)] = wa;
    mem[longint'(base + 24)] = wb;
    if (bad_a) bad[longint'(base + 16)] = 1;
    if (bad_b) bad[longint'(base + 24)] = 1;
    e.base = base;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_opcode = 8'h0E;
    cmd_base   = base;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic exp_t mk_exp(input bit st, input bit lg, input bit mv,
                                  input int s, input int d, input int nr, input string req);
    exp_t e;
    e.stall = st; e.log_err = lg; e.moved = mv;
    e.src = IDX_W'(s); e.dst = IDX_W'(d); e.nreads = nr; e.base = '0; e.req = req;
    return e;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R9 reset state
    check(cmd_ready == 1'b1, "R9", "cmd_ready after reset", cmd_ready, 1);
    check(rd_req_valid == 1'b0, "R9", "rd_req_valid after reset", rd_req_valid, 0);
    check(mv_start == 1'b0, "R9", "mv_start after reset", mv_start, 0);
    check(res_valid == 1'b0, "R9", "res_valid after reset", res_valid, 0);

    // R1: wrong opcode is not taken
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = 8'h0C; cmd_base = 48'h500;
    repeat (6) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk); #2;
    check(total_reads == 0, "R1", "reads for other opcode", total_reads, 0);
    check(results_seen == 0, "R1", "results for other opcode", results_seen, 0);
    check(cmd_ready == 1'b1, "R1", "still idle", cmd_ready, 1);

    // R8: spurious done while idle is ignored
    @(negedge clk); spur_done = 1'b1;
    @(negedge clk); spur_done = 1'b0;

    // commands back to back
    issue(48'h1000, mk_word(1, 0, 0), mk_word(5, 0, 0), 0, 0, mk_exp(0, 0, 1, 1, 5, 2, "R8"));
    issue(48'h1020, mk_word(NT, 0, 0), mk_word(2, 0, 0), 0, 0, mk_exp(0, 1, 0, 0, 0, 1, "R5"));
    issue(48'h1040, mk_word(2, 0, 0), mk_word(200, 0, 0), 0, 0, mk_exp(0, 1, 0, 0, 0, 2, "R6"));
    issue(48'h1060, mk_word(3, 0, 0), mk_word(3, 0, 0), 0, 0, mk_exp(0, 0, 0, 0, 0, 2, "R7"));
    issue(48'h1080, mk_word(1, 0, 0), mk_word(2, 0, 0), 1, 0, mk_exp(1, 0, 0, 0, 0, 1, "R4"));
    issue(48'h10A0, mk_word(1, 0, 0), mk_word(2, 0, 0), 0, 1, mk_exp(1, 0, 0, 0, 0, 2, "R4"));
    issue(48'h10C0, mk_word(7, 12'hFFF, 16'hFFFF), mk_word(0, 12'hABC, 16'h1234), 0, 0,
          mk_exp(0, 0, 1, 7, 0, 2, "R3"));
    issue(48'h10E0, mk_word(2, 12'h800, 16'h0001), mk_word(2, 12'h001, 16'h8000), 0, 0,
          mk_exp(0, 0, 0, 0, 0, 2, "R3"));
    issue(48'h1100, mk_word(IDX_W'(64'hF_FFFF_FFFF), 0, 0), mk_word(1, 0, 0), 0, 0,
          mk_exp(0, 1, 0, 0, 0, 1, "R5"));
    issue(48'h1120, mk_word(6, 0, 0), mk_word(NT - 1, 0, 0), 0, 0, mk_exp(0, 0, 1, 6, 7, 2, "R8"));
    issue(48'h1140, mk_word(0, 0, 0), mk_word(NT, 0, 0), 0, 0, mk_exp(0, 1, 0, 0, 0, 2, "R6"));

    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk); #2;
    check(results_seen == 11, "R9", "one result per command", results_seen, 11);
    check(cmd_ready == 1'b1, "R9", "idle at end", cmd_ready, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule